// File: doc/BRIEF.md
# Cycle-Bit Transfer Ring Consumer

The block walks a transfer ring on behalf of an endpoint and decides which entries software has handed over. Each entry is a 16-byte block read whole through a memory read port. The consumer keeps a dequeue pointer and a one-bit cycle state. An entry belongs to the consumer only when the entry's cycle bit matches that state. There is no head/tail comparison. The ring is made of segments. A link entry at the end of each segment sends the pointer to the next segment. The link that closes the ring flips the cycle state, so stale entries from the previous pass read as not owned.

Work starts with a doorbell pulse. Consecutive entries with the chain bit set form one descriptor. When the descriptor's last entry is consumed, the block posts a completion event and raises an interrupt pulse. A halt input stops the walk at once, and a halted consumer ignores doorbells. Software recovers by loading a new dequeue pointer and cycle state past the stalled descriptor. That load clears the halt, and the next doorbell resumes from the new position.

Top module: `trb_ring_consumer`

## Requirements
- R1: After reset the dequeue pointer is 0, the cycle state is 1, `halted` is 0, and neither `rd_en` nor `evt_valid` is asserted.
- R2: No entry is read until a doorbell pulse arrives while the block is idle and not halted.
- R3: An entry is consumed only when its cycle bit (bit 0 of the fourth dword, entry bit 96) equals the cycle state. Otherwise the block stops, the pointer stays on that entry, and no further read happens until the next doorbell.
- R4: The chain bit is entry bit 100. A descriptor ends at the first consumed entry whose chain bit is clear. Each descriptor produces exactly one event carrying that entry's address and completion code 1, and a descriptor may continue across a link.
- R5: An entry whose type field (entry bits 111:106) equals 6 is a link. It is never reported, and it sets the pointer to the target held in the low bits of the first dword.
- R6: A link whose toggle bit (entry bit 97) is set inverts the cycle state when followed. A link without it leaves the cycle state unchanged.
- R7: `evt_valid` is a one-cycle pulse, `irq` is high in the same cycle, and the code is 1.
- R8: A `halt_req` pulse stops processing at once, abandons any partly consumed descriptor without an event, and sets `halted`.
- R9: While `halted` is 1, doorbell pulses cause no reads and no events.
- R10: A `deq_load` pulse sets the pointer to `deq_ptr_in` and the cycle state to `deq_cycle_in`, and clears `halted`. No read happens until the next doorbell, so the entries of a skipped descriptor are never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| doorbell | input | 1 | Pulse: work may be available |
| halt_req | input | 1 | Pulse: stop processing and enter the halted state |
| deq_load | input | 1 | Pulse: load pointer and cycle state, clear halt |
| deq_ptr_in | input | AW | Entry index to load |
| deq_cycle_in | input | 1 | Cycle state to load |
| rd_en | output | 1 | Read request for one entry |
| rd_addr | output | AW | Entry index being read |
| rd_data | input | 128 | Entry contents, valid the cycle after `rd_en` |
| evt_valid | output | 1 | Completion event pulse |
| evt_addr | output | AW | Address of the descriptor's last entry |
| evt_code | output | CW | Completion code (1 = success) |
| irq | output | 1 | Interrupt pulse accompanying an event |
| halted | output | 1 | Consumer is halted |
| deq_ptr | output | AW | Current dequeue pointer |
| cycle_state | output | 1 | Current consumer cycle state |

## Verification
The assertions assume the read port answers with the addressed entry exactly one cycle after `rd_en`. They also assume control inputs are single-cycle pulses, and that link targets lie inside the addressable range. The bench memory model is a registered array with that one-cycle latency. The bench changes ring contents only while the consumer has stopped on a non-owned entry or is halted, so no entry is rewritten while it is being read. Doorbell, halt and load are driven as one-cycle pulses away from the clock edge.

// File: rtl/trb_ring_pkg.sv
package trb_ring_pkg;

  localparam int TRB_BITS = 128;
  localparam int DW3_LSB = 96;
  localparam logic [5:0] TYPE_LINK = 6'd6;
  localparam logic [7:0] CODE_SUCCESS = 8'd1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK
  } cons_state_t;

  function automatic logic trb_cycle(input logic [TRB_BITS-1:0] e);
    return e[DW3_LSB + 0];
  endfunction

  function automatic logic trb_toggle(input logic [TRB_BITS-1:0] e);
    return e[DW3_LSB + 1];
  endfunction

  function automatic logic trb_chain(input logic [TRB_BITS-1:0] e);
    return e[DW3_LSB + 4];
  endfunction

  function automatic logic [5:0] trb_type(input logic [TRB_BITS-1:0] e);
    return e[DW3_LSB + 15 -: 6];
  endfunction

  function automatic logic [31:0] trb_target(input logic [TRB_BITS-1:0] e);
    return e[31:0];
  endfunction

endpackage

// File: rtl/trb_decode.sv
module trb_decode
  import trb_ring_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic [TRB_BITS-1:0] entry,
  input  logic                ccs,
  output logic                owned,
  output logic                is_link,
  output logic                chain,
  output logic                toggle,
  output logic [AW-1:0]       target
);

  logic unused_entry_bits;

  always_comb begin
    owned   = (trb_cycle(entry) == ccs);
    is_link = (trb_type(entry) == TYPE_LINK);
    chain   = trb_chain(entry);
    toggle  = trb_toggle(entry);
    target  = AW'(trb_target(entry));
  end

  assign unused_entry_bits = ^entry;

endmodule

// File: rtl/trb_deq_ptr.sv
module trb_deq_ptr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_ptr,
  input  logic          load_cycle,
  input  logic          advance,
  input  logic          link_take,
  input  logic [AW-1:0] link_target,
  input  logic          link_toggle,
  output logic [AW-1:0] deq_ptr,
  output logic          cycle_state
);

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deq_ptr     <= '0;
      cycle_state <= 1'b1;
    end else if (load) begin
      deq_ptr     <= load_ptr;
      cycle_state <= load_cycle;
    end else if (link_take) begin
      deq_ptr <= link_target;
      if (link_toggle) cycle_state <= ~cycle_state;
    end else if (advance) begin
      deq_ptr <= ptr_step(deq_ptr);
    end
  end

  AST_LINK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && link_take && link_toggle) |=> (cycle_state != $past(cycle_state))); // R6
  AST_LINK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && link_take && !link_toggle) |=> (cycle_state == $past(cycle_state))); // R6
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (deq_ptr == $past(load_ptr) && cycle_state == $past(load_cycle))); // R10

endmodule

// File: rtl/trb_evt_gen.sv
module trb_evt_gen
  import trb_ring_pkg::*;
#(
  parameter int AW = 6,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [AW-1:0] fire_addr,
  output logic          evt_valid,
  output logic [AW-1:0] evt_addr,
  output logic [CW-1:0] evt_code,
  output logic          irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid <= 1'b0;
      irq       <= 1'b0;
      evt_addr  <= '0;
      evt_code  <= '0;
    end else begin
      evt_valid <= fire;
      irq       <= fire;
      if (fire) begin
        evt_addr <= fire_addr;
        evt_code <= CW'(CODE_SUCCESS);
      end
    end
  end

  AST_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid); // R7

endmodule

// File: rtl/trb_ring_consumer.sv
module trb_ring_consumer
  import trb_ring_pkg::*;
#(
  parameter int AW = 6,
  parameter int CW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                doorbell,
  input  logic                halt_req,
  input  logic                deq_load,
  input  logic [AW-1:0]       deq_ptr_in,
  input  logic                deq_cycle_in,
  output logic                rd_en,
  output logic [AW-1:0]       rd_addr,
  input  logic [TRB_BITS-1:0] rd_data,
  output logic                evt_valid,
  output logic [AW-1:0]       evt_addr,
  output logic [CW-1:0]       evt_code,
  output logic                irq,
  output logic                halted,
  output logic [AW-1:0]       deq_ptr,
  output logic                cycle_state
);

  cons_state_t state;
  logic        db_pend;

  // decoded fields of the entry on rd_data
  logic          e_owned, e_link, e_chain, e_toggle;
  logic [AW-1:0] e_target;

  // named internal events
  logic chk, own_hit, own_miss, link_take, advance, fire;

  trb_decode #(.AW(AW)) u_decode (
    .entry   (rd_data),
    .ccs     (cycle_state),
    .owned   (e_owned),
    .is_link (e_link),
    .chain   (e_chain),
    .toggle  (e_toggle),
    .target  (e_target)
  );

  always_comb begin
    chk       = (state == ST_CHECK) && !deq_load && !halt_req;
    own_hit   = chk && e_owned;
    own_miss  = chk && !e_owned;
    link_take = own_hit && e_link;
    advance   = own_hit && !e_link;
    fire      = advance && !e_chain;
    rd_en     = (state == ST_FETCH);
    rd_addr   = deq_ptr;
  end

  trb_deq_ptr #(.AW(AW)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (deq_load),
    .load_ptr    (deq_ptr_in),
    .load_cycle  (deq_cycle_in),
    .advance     (advance),
    .link_take   (link_take),
    .link_target (e_target),
    .link_toggle (e_toggle),
    .deq_ptr     (deq_ptr),
    .cycle_state (cycle_state)
  );

  trb_evt_gen #(.AW(AW), .CW(CW)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .fire_addr (deq_ptr),
    .evt_valid (evt_valid),
    .evt_addr  (evt_addr),
    .evt_code  (evt_code),
    .irq       (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      halted  <= 1'b0;
      db_pend <= 1'b0;
    end else if (deq_load) begin
      state   <= ST_IDLE;
      halted  <= 1'b0;
      db_pend <= 1'b0;
    end else if (halt_req) begin
      state   <= ST_IDLE;
      halted  <= 1'b1;
      db_pend <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (doorbell && !halted) state <= ST_FETCH;
        end
        ST_FETCH: begin
          state <= ST_CHECK;
          if (doorbell) db_pend <= 1'b1;
        end
        ST_CHECK: begin
          if (own_miss) begin
            state   <= (db_pend || doorbell) ? ST_FETCH : ST_IDLE;
            db_pend <= 1'b0;
          end else begin
            state <= ST_FETCH;
            if (doorbell) db_pend <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_NEEDS_DB: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !doorbell) |=> !rd_en); // R2
  AST_MISS_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (own_miss && !db_pend && !doorbell) |=> (state == ST_IDLE)); // R3
  AST_MISS_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    own_miss |=> (deq_ptr == $past(deq_ptr))); // R3
  AST_EVT_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> ($past(rd_en, 2) && evt_addr == $past(rd_addr, 2))); // R4
  AST_LINK_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    link_take |=> !evt_valid); // R5
  AST_HALT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !deq_load) |=> (halted && !evt_valid && !rd_en)); // R8
  AST_HALT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !rd_en); // R9

endmodule

// File: tb/test_trb_ring_consumer.sv
`timescale 1ns/1ps
module test_trb_ring_consumer;

  localparam int AW = 6;
  localparam int CW = 8;
  localparam int NDESC = 6;
  localparam int DESC_LEN [NDESC] = '{3, 2, 1, 6, 3, 3};

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           doorbell = 1'b0, halt_req = 1'b0, deq_load = 1'b0;
  logic [AW-1:0]  deq_ptr_in = '0;
  logic           deq_cycle_in = 1'b0;
  logic           rd_en;
  logic [AW-1:0]  rd_addr;
  logic [127:0]   rd_data = '0;
  logic           evt_valid, irq, halted, cycle_state;
  logic [AW-1:0]  evt_addr, deq_ptr;
  logic [CW-1:0]  evt_code;

  logic [127:0]   mem [64];
  int             checks = 0, failures = 0;
  int             rd_cnt = 0, evt_bad = 0;
  bit             prev_evt = 1'b0;
  logic [AW-1:0]  ev_q [$];

  always #4 clk = ~clk;

  trb_ring_consumer #(.AW(AW), .CW(CW)) i_trb_ring_consumer (
    .clk(clk), .rst_n(rst_n), .doorbell(doorbell), .halt_req(halt_req),
    .deq_load(deq_load), .deq_ptr_in(deq_ptr_in), .deq_cycle_in(deq_cycle_in),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_valid(evt_valid), .evt_addr(evt_addr), .evt_code(evt_code), .irq(irq),
    .halted(halted), .deq_ptr(deq_ptr), .cycle_state(cycle_state)
  );

  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_en) rd_cnt++;
      if (evt_valid) begin
        ev_q.push_back(evt_addr);
        if (!irq || evt_code != 8'd1) evt_bad++;
        if (prev_evt) evt_bad++;
      end
      prev_evt = evt_valid;
    end
  end

  function automatic logic [127:0] mk(bit cyc, bit ch, bit lk, bit tg, int tgt);
    logic [127:0] e = '0;
    e[31:0] = tgt;
    e[96]   = cyc;
    e[97]   = tg;
    e[100]  = ch;
    if (lk) e[111:106] = 6'd6;
    return e;
  endfunction

  function automatic int work_addr(int k);
    return (k < 11) ? k : 32 + (k - 11);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_db();
    @(negedge clk) doorbell = 1'b1;
    @(negedge clk) doorbell = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_200_000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int k;
    int base;
    int rbase;
    int exp_q [$];
    for (int i = 0; i < 64; i++) mem[i] = '0;
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(deq_ptr == 0, "R1 ptr", deq_ptr, 0);
    check(cycle_state == 1'b1, "R1 cycle", cycle_state, 1);
    check(halted == 1'b0, "R1 halted", halted, 0);
    check(!rd_en && !evt_valid, "R1 idle outputs", rd_en, 0);

    // build ring from the descriptor table
    k = 0;
    for (int d = 0; d < NDESC; d++) begin
      for (int j = 0; j < DESC_LEN[d]; j++) begin
        mem[work_addr(k)] = mk(1'b1, j != DESC_LEN[d] - 1, 1'b0, 1'b0, 0);
        k++;
      end
      exp_q.push_back(work_addr(k - 1));
    end
    mem[11] = mk(1'b1, 1'b0, 1'b1, 1'b0, 32);
    mem[39] = mk(1'b1, 1'b0, 1'b1, 1'b1, 0);

    // R2 nothing happens before the doorbell
    rbase = rd_cnt;
    idle(20);
    check(rd_cnt == rbase, "R2 no read before doorbell", rd_cnt - rbase, 0);

    // full pass: R4 R5 R6
    base = ev_q.size();
    pulse_db();
    idle(120);
    check(ev_q.size() - base == NDESC, "R4 event count", ev_q.size() - base, NDESC);
    for (int i = 0; i < NDESC; i++)
      if (ev_q.size() > base + i)
        check(ev_q[base + i] == exp_q[i], "R4/R5 event address", ev_q[base + i], exp_q[i]);
    check(deq_ptr == 0, "R6 ptr wrapped", deq_ptr, 0);
    check(cycle_state == 1'b0, "R6 cycle flipped", cycle_state, 0);

    // R3 ownership: only entries 0..4 handed over in the new pass
    for (int i = 0; i < 3; i++) mem[i] = mk(1'b0, i != 2, 1'b0, 1'b0, 0);
    mem[3] = mk(1'b0, 1'b1, 1'b0, 1'b0, 0);
    mem[4] = mk(1'b0, 1'b0, 1'b0, 1'b0, 0);
    base = ev_q.size();
    pulse_db();
    idle(40);
    check(ev_q.size() - base == 2, "R3 event count", ev_q.size() - base, 2);
    if (ev_q.size() >= base + 2) begin
      check(ev_q[base] == 2, "R3 first event", ev_q[base], 2);
      check(ev_q[base + 1] == 4, "R3 second event", ev_q[base + 1], 4);
    end
    check(deq_ptr == 5, "R3 stopped at stale entry", deq_ptr, 5);
    rbase = rd_cnt;
    idle(20);
    check(rd_cnt == rbase, "R3 waits for doorbell", rd_cnt - rbase, 0);

    // R8 halt mid-descriptor
    mem[5] = mk(1'b0, 1'b1, 1'b0, 1'b0, 0);
    mem[6] = mk(1'b0, 1'b1, 1'b0, 1'b0, 0);
    base = ev_q.size();
    pulse_db();
    idle(30);
    check(deq_ptr == 7, "R3 waiting mid-descriptor", deq_ptr, 7);
    @(negedge clk) halt_req = 1'b1;
    @(negedge clk) halt_req = 1'b0;
    check(halted == 1'b1, "R8 halted set", halted, 1);

    // R9 doorbell ignored while halted
    mem[7] = mk(1'b0, 1'b0, 1'b0, 1'b0, 0);
    mem[8] = mk(1'b0, 1'b0, 1'b0, 1'b0, 0);
    rbase = rd_cnt;
    pulse_db();
    idle(20);
    check(rd_cnt == rbase, "R9 no read while halted", rd_cnt - rbase, 0);
    check(ev_q.size() == base, "R8 no event for abandoned descriptor", ev_q.size() - base, 0);
    check(deq_ptr == 7, "R9 pointer unchanged", deq_ptr, 7);

    // R10 pointer load past the stalled descriptor
    @(negedge clk) begin deq_load = 1'b1; deq_ptr_in = 6'd8; deq_cycle_in = 1'b0; end
    @(negedge clk) deq_load = 1'b0;
    check(halted == 1'b0, "R10 halt cleared", halted, 0);
    check(deq_ptr == 8, "R10 ptr loaded", deq_ptr, 8);
    check(cycle_state == 1'b0, "R10 cycle loaded", cycle_state, 0);
    rbase = rd_cnt;
    idle(10);
    check(rd_cnt == rbase, "R10 waits for doorbell", rd_cnt - rbase, 0);
    pulse_db();
    idle(30);
    check(ev_q.size() - base == 1, "R10 one event after load", ev_q.size() - base, 1);
    if (ev_q.size() > base)
      check(ev_q[base] == 8, "R10 skipped entry 7", ev_q[base], 8);
    check(deq_ptr == 9, "R10 ptr after resume", deq_ptr, 9);

    // R7 pulse shape, irq and code across all events
    check(evt_bad == 0, "R7 event pulse/irq/code", evt_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule